// File: doc/BRIEF.md
# Pre-Adder and Multiplier Input Stage

This block is the front half of a multiply-accumulate slice. It takes an A operand, a D operand and a B operand through optional register stages and combines A and D in a 25-bit pre-adder. It multiplies the pre-adder result by a signed 18-bit B value to form the product M. M is then sign-extended to 48 bits for a post-adder that is outside this block.

A 5-bit mode word is applied on every cycle. It picks between the first and second pipeline copies of A and of B, and it can force A to zero, add D, or negate A. This gives (D+A)·B, (D−A)·B, −A·B, D·B, A·B or zero without any added logic around the block. Static parameters set the A source (direct or cascade input) and the depth of each register stage. Each stage has its own clock enable and synchronous reset.

Top module: `preadd_mult_stage`

## Requirements
- R1: Parameter A_FROM_CASCADE=1 takes the A operand from a_casc_in, and 0 takes it from a_in. The unselected input has no effect on m_out.
- R2: The A and B paths have 0, 1 or 2 stages each. D, the pre-adder output, the mode word and M have 0 or 1 stage each. Each stage adds exactly one cycle of latency.
- R3: Mode bit 0 set selects the first A copy (A1), and bit 0 clear selects the second (A2). With two A stages, A2 is A1 delayed by one enabled cycle. With one stage, A1 and A2 are the same register, loaded on ce_a2.
- R4: Mode bit 1 set forces the A operand to zero before negation and before D is added.
- R5: With USE_D=1, mode bit 2 adds D into the pre-adder and mode bit 3 negates the A operand. The pre-adder result wraps to 25 bits.
- R6: With USE_D=0, mode bits 2 and 3 are ignored, so the pre-adder output is A1, A2 or zero.
- R7: Mode bit 4 set selects the first B copy (B1), and bit 4 clear selects the second (B2). B2 is B1 delayed by one enabled cycle.
- R8: m_out is the signed product of the 25-bit pre-adder result and the selected 18-bit B value, sign-extended to 48 bits.
- R9: A register whose clock enable is low keeps its value. After a reset, it keeps outputting zero until its enable rises.
- R10: Each synchronous reset clears its registers to zero on the next clock edge and takes priority over the clock enable.
- R11: With MODE_STAGE=1, a change of mode_in takes effect on m_out only after the next clock edge on which ce_mode is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a | input | 1 | Synchronous reset of the A registers |
| rst_b | input | 1 | Synchronous reset of the B registers |
| rst_d | input | 1 | Synchronous reset of the D and pre-adder registers |
| rst_m | input | 1 | Synchronous reset of the product register |
| rst_mode | input | 1 | Synchronous reset of the mode register |
| ce_a1 | input | 1 | Enable of the first A stage |
| ce_a2 | input | 1 | Enable of the second (or only) A stage |
| ce_b1 | input | 1 | Enable of the first B stage |
| ce_b2 | input | 1 | Enable of the second (or only) B stage |
| ce_d | input | 1 | Enable of the D register |
| ce_ad | input | 1 | Enable of the pre-adder output register |
| ce_m | input | 1 | Enable of the product register |
| ce_mode | input | 1 | Enable of the mode register |
| mode_in | input | 5 | Operand select, gate, add and negate controls |
| a_in | input | AW | Direct A operand |
| a_casc_in | input | AW | Cascade A operand |
| b_in | input | BW | B operand |
| d_in | input | AW | D operand for the pre-adder |
| m_out | output | PW | Sign-extended product |

## Verification
A table of steady operands is run through every pre-adder mode: plain A, D+A, D−A, −A, D alone, gated zero, and D with A gated. Each mode gives a different product for the same operands, so a swapped or dropped mode bit shows up. Signed negative operands, the 25-bit wrap of D+A and the most negative 18-bit B check the signed arithmetic and the sign extension. Directed steps change A or B one cycle before sampling, so A1 differs from A2 and B1 differs from B2 and the select bits can be told apart. A second instance has bypassed stages, the cascade source and D disabled. It shows that the unselected A input and mode bits 2 and 3 have no effect, and that a registered mode word applies one edge late.

// File: rtl/preadd_mult_stage.sv
module preadd_mult_stage #(
  parameter int AW             = 25,
  parameter int BW             = 18,
  parameter int PW             = 48,
  parameter bit A_FROM_CASCADE = 1'b0,
  parameter int A_STAGES       = 2,
  parameter int B_STAGES       = 2,
  parameter bit D_STAGE        = 1'b1,
  parameter bit AD_STAGE       = 1'b1,
  parameter bit M_STAGE        = 1'b1,
  parameter bit MODE_STAGE     = 1'b1,
  parameter bit USE_D          = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_a,
  input  logic                 rst_b,
  input  logic                 rst_d,
  input  logic                 rst_m,
  input  logic                 rst_mode,
  input  logic                 ce_a1,
  input  logic                 ce_a2,
  input  logic                 ce_b1,
  input  logic                 ce_b2,
  input  logic                 ce_d,
  input  logic                 ce_ad,
  input  logic                 ce_m,
  input  logic                 ce_mode,
  input  logic [4:0]           mode_in,
  input  logic signed [AW-1:0] a_in,
  input  logic signed [AW-1:0] a_casc_in,
  input  logic signed [BW-1:0] b_in,
  input  logic signed [AW-1:0] d_in,
  output logic signed [PW-1:0] m_out
);
  localparam int MW = AW + BW;

  logic signed [AW-1:0] a_src, a1_q, a2_q, d_q, a_sel, pre_sum, ad_q;
  logic signed [BW-1:0] b1_q, b2_q, b_sel;
  logic [4:0]           mode_q;
  logic signed [MW-1:0] prod, m_q;

  wire unused_ok = ^{a_in, a_casc_in, ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_ad,
                     ce_m, ce_mode, rst_a, rst_b, rst_d, rst_m, rst_mode, d_in};

  assign a_src = A_FROM_CASCADE ? a_casc_in : a_in;

  generate
    if (MODE_STAGE) begin : g_mode_reg
      logic [4:0] r;
      always_ff @(posedge clk)
        if (rst_mode) r <= '0;
        else if (ce_mode) r <= mode_in;
      assign mode_q = r;
    end else begin : g_mode_byp
      assign mode_q = mode_in;
    end

    if (A_STAGES == 0) begin : g_a0
      assign a1_q = a_src;
      assign a2_q = a_src;
    end else if (A_STAGES == 1) begin : g_a1
      logic signed [AW-1:0] r;
      always_ff @(posedge clk)
        if (rst_a) r <= '0;
        else if (ce_a2) r <= a_src;
      assign a1_q = r;
      assign a2_q = r;
    end else begin : g_a2
      logic signed [AW-1:0] r1, r2;
      always_ff @(posedge clk)
        if (rst_a) begin
          r1 <= '0;
          r2 <= '0;
        end else begin
          if (ce_a1) r1 <= a_src;
          if (ce_a2) r2 <= r1;
        end
      assign a1_q = r1;
      assign a2_q = r2;
    end

    if (B_STAGES == 0) begin : g_b0
      assign b1_q = b_in;
      assign b2_q = b_in;
    end else if (B_STAGES == 1) begin : g_b1
      logic signed [BW-1:0] r;
      always_ff @(posedge clk)
        if (rst_b) r <= '0;
        else if (ce_b2) r <= b_in;
      assign b1_q = r;
      assign b2_q = r;
    end else begin : g_b2
      logic signed [BW-1:0] r1, r2;
      always_ff @(posedge clk)
        if (rst_b) begin
          r1 <= '0;
          r2 <= '0;
        end else begin
          if (ce_b1) r1 <= b_in;
          if (ce_b2) r2 <= r1;
        end
      assign b1_q = r1;
      assign b2_q = r2;
    end

    if (D_STAGE) begin : g_d_reg
      logic signed [AW-1:0] r;
      always_ff @(posedge clk)
        if (rst_d) r <= '0;
        else if (ce_d) r <= d_in;
      assign d_q = r;
    end else begin : g_d_byp
      assign d_q = d_in;
    end
  endgenerate

  always_comb begin
    a_sel = mode_q[1] ? '0 : (mode_q[0] ? a1_q : a2_q);
    if (USE_D)
      pre_sum = (mode_q[3] ? -a_sel : a_sel) + (mode_q[2] ? d_q : '0);
    else
      pre_sum = a_sel;
  end

  generate
    if (AD_STAGE) begin : g_ad_reg
      logic signed [AW-1:0] r;
      always_ff @(posedge clk)
        if (rst_d) r <= '0;
        else if (ce_ad) r <= pre_sum;
      assign ad_q = r;
    end else begin : g_ad_byp
      assign ad_q = pre_sum;
    end
  endgenerate

  assign b_sel = mode_q[4] ? b1_q : b2_q;
  assign prod  = $signed({{BW{ad_q[AW-1]}}, ad_q}) * $signed({{AW{b_sel[BW-1]}}, b_sel});

  generate
    if (M_STAGE) begin : g_m_reg
      logic signed [MW-1:0] r;
      always_ff @(posedge clk)
        if (rst_m) r <= '0;
        else if (ce_m) r <= prod;
      assign m_q = r;
    end else begin : g_m_byp
      assign m_q = prod;
    end
  endgenerate

  assign m_out = {{(PW-MW){m_q[MW-1]}}, m_q};
endmodule

// File: rtl/preadd_mult_stage_chk.sv
module preadd_mult_stage_chk #(
  parameter int AW       = 25,
  parameter int PW       = 48,
  parameter int MW       = 43,
  parameter int A_STAGES = 2,
  parameter bit M_STAGE  = 1'b1,
  parameter bit USE_D    = 1'b1
) (
  input logic          clk,
  input logic          rst_a,
  input logic          rst_m,
  input logic          rst_mode,
  input logic          ce_a2,
  input logic          ce_m,
  input logic [4:0]    mode_q,
  input logic [AW-1:0] a1_q,
  input logic [AW-1:0] a2_q,
  input logic [AW-1:0] pre_sum,
  input logic [PW-1:0] m_out
);
  a_r3_a2_follows_a1: assert property (@(posedge clk) disable iff (rst_a)
    (A_STAGES == 2 && ce_a2) |=> (a2_q == $past(a1_q)));

  a_r4_zero_gate: assert property (@(posedge clk) disable iff (rst_mode)
    (mode_q[1] && !(USE_D && (mode_q[2] || mode_q[3]))) |-> (pre_sum == '0));

  a_r8_sign_extend: assert property (@(posedge clk) disable iff (rst_m)
    ($countones(m_out[PW-1:MW-1]) == 0) || ($countones(m_out[PW-1:MW-1]) == PW-MW+1));

  a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (rst_m)
    (M_STAGE && !ce_m) |=> $stable(m_out));

  a_r10_reset_clears: assert property (@(posedge clk)
    (M_STAGE && rst_m) |=> (m_out == '0));
endmodule

bind preadd_mult_stage preadd_mult_stage_chk #(
  .AW(AW), .PW(PW), .MW(AW + BW), .A_STAGES(A_STAGES), .M_STAGE(M_STAGE), .USE_D(USE_D)
) u_chk (
  .clk(clk), .rst_a(rst_a), .rst_m(rst_m), .rst_mode(rst_mode), .ce_a2(ce_a2),
  .ce_m(ce_m), .mode_q(mode_q), .a1_q(a1_q), .a2_q(a2_q), .pre_sum(pre_sum), .m_out(m_out)
);

// File: tb/preadd_mult_stage_test.sv
module preadd_mult_stage_test;
  localparam int PERIOD = 10;
  localparam int NV = 10;

  localparam logic signed [24:0] VA [NV] = '{25'sd100, 25'sd100, 25'sd100, 25'sd100, 25'sd100,
                                             25'sd100, 25'sd100, -25'sd3, 25'sd16777215, -25'sd16777216};
  localparam logic signed [17:0] VB [NV] = '{18'sd200, 18'sd200, 18'sd200, 18'sd200, 18'sd200,
                                             18'sd200, 18'sd200, -18'sd7, 18'sd2, -18'sd131072};
  localparam logic signed [24:0] VD [NV] = '{25'sd45, 25'sd45, 25'sd45, 25'sd45, 25'sd45,
                                             25'sd45, 25'sd45, 25'sd0, 25'sd1, 25'sd0};
  localparam logic [4:0] VM [NV] = '{5'b00000, 5'b00100, 5'b01100, 5'b01000, 5'b00110,
                                     5'b00010, 5'b01110, 5'b10001, 5'b00100, 5'b00000};
  localparam logic signed [47:0] VE [NV] = '{48'sd20000, 48'sd29000, -48'sd11000, -48'sd20000, 48'sd9000,
                                             48'sd0, 48'sd9000, 48'sd21, -48'sd33554432, 48'sd2199023255552};

  logic clk = 1'b0;
  logic rst;
  logic ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_mode;
  logic [4:0] mode;
  logic signed [24:0] a, ac, d;
  logic signed [17:0] b;
  logic signed [47:0] m_out, alt_m;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  preadd_mult_stage #(.A_STAGES(2), .B_STAGES(2), .D_STAGE(1), .AD_STAGE(0), .M_STAGE(1),
                      .MODE_STAGE(0), .USE_D(1)) uut (
    .clk(clk), .rst_a(rst), .rst_b(rst), .rst_d(rst), .rst_m(rst), .rst_mode(rst),
    .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1), .ce_b2(ce_b2), .ce_d(ce_d), .ce_ad(ce_ad),
    .ce_m(ce_m), .ce_mode(ce_mode), .mode_in(mode), .a_in(a), .a_casc_in(ac), .b_in(b),
    .d_in(d), .m_out(m_out));

  preadd_mult_stage #(.A_FROM_CASCADE(1), .A_STAGES(0), .B_STAGES(0), .D_STAGE(0), .AD_STAGE(0),
                      .M_STAGE(0), .MODE_STAGE(1), .USE_D(0)) uut_alt (
    .clk(clk), .rst_a(rst), .rst_b(rst), .rst_d(rst), .rst_m(rst), .rst_mode(rst),
    .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1), .ce_b2(ce_b2), .ce_d(ce_d), .ce_ad(ce_ad),
    .ce_m(ce_m), .ce_mode(ce_mode), .mode_in(mode), .a_in(a), .a_casc_in(ac), .b_in(b),
    .d_in(d), .m_out(alt_m));

  task automatic check(input string req, input logic signed [47:0] act, input logic signed [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    {ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_mode} = '1;
    mode = '0; a = 25'sd100; ac = '0; b = 18'sd200; d = '0;
    settle(2);
    check("R10 reset clears product", m_out, 48'sd0);
    rst = 1'b0;

    // R5 R8 vector table
    for (int i = 0; i < NV; i++) begin
      a = VA[i]; b = VB[i]; d = VD[i]; mode = VM[i];
      settle(4);
      check($sformatf("R5/R8 vector %0d", i), m_out, VE[i]);
    end

    // R2 latency: three edges from A input to product
    a = 25'sd5; b = 18'sd10; d = '0; mode = 5'b00000;
    settle(4);
    a = 25'sd7;
    settle(2);
    check("R2 latency, old value after two edges", m_out, 48'sd50);
    settle(1);
    check("R2 latency, new value after three edges", m_out, 48'sd70);

    // R3 A1 versus A2
    a = 25'sd50; b = 18'sd3; mode = 5'b00000;
    settle(4);
    a = 25'sd70; mode = 5'b00001;
    settle(2);
    check("R3 bit0=1 selects A1", m_out, 48'sd210);
    a = 25'sd50; mode = 5'b00000;
    settle(4);
    a = 25'sd70;
    settle(2);
    check("R3 bit0=0 selects A2", m_out, 48'sd150);

    // R7 B1 versus B2
    a = 25'sd5; b = 18'sd10; mode = 5'b00000;
    settle(4);
    b = 18'sd20; mode = 5'b10000;
    settle(2);
    check("R7 bit4=1 selects B1", m_out, 48'sd100);
    b = 18'sd10; mode = 5'b00000;
    settle(4);
    b = 18'sd20;
    settle(2);
    check("R7 bit4=0 selects B2", m_out, 48'sd50);

    // R9 clock enable low
    a = 25'sd5; b = 18'sd10; mode = 5'b00000;
    settle(4);
    ce_m = 1'b0; a = 25'sd9;
    settle(4);
    check("R9 product held with enable low", m_out, 48'sd50);
    rst = 1'b1;
    settle(1);
    rst = 1'b0;
    settle(3);
    check("R9 stays zero after reset with enable low", m_out, 48'sd0);
    ce_m = 1'b1;
    settle(1);
    check("R9 loads once enable rises", m_out, 48'sd90);

    // R1 R6 R11 on the bypassed, cascade-fed instance
    a = 25'sd11; ac = 25'sd13; b = 18'sd4; d = 25'sd45; mode = 5'b01100;
    settle(2);
    check("R1/R6 cascade A used, D and negate ignored", alt_m, 48'sd52);
    mode = 5'b01110;
    #1;
    check("R11 mode change not seen before the edge", alt_m, 48'sd52);
    settle(1);
    check("R11 R4 registered zero gate applied after the edge", alt_m, 48'sd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule